// File: doc/BRIEF.md
# External Memory Wait-State Controller

This block bridges a 16-bit on-chip processor bus and an asynchronous external memory bus. Every processor access is routed to one of three external regions, chosen by the two top address bits: a general extended-memory window, a RAM window and a ROM window. Each region has its own active-low chip select. The read strobe, write strobe, address and data lines are shared by all three regions.

A 14-bit control register sets, for each region, a stretch of zero to seven extra clock cycles and a data width of 8 or 16 bits. When a 16-bit access goes to a region set to 8 bits, the block runs it as two byte cycles. Two merge flags make the RAM select, the ROM select or both follow the extended-memory select. This lets one device answer to both windows.

The processor raises a request and holds its address, direction and write data steady until the block pulses ready. The block latches the region settings when it accepts the request, so a register write made during an access does not change that access.

Top module: `xmem_wait_ctrl`

## Requirements
- R1: Region decode uses address bits [ADDR_W-1:ADDR_W-2]. The code 2'b11 selects ROM, 2'b10 selects RAM, and every other code selects extended memory. With both merge flags clear, at most one chip select is low at any time.
- R2: Control register layout:
  - bits 2:0 hold the RAM wait count and bit 3 is the RAM width (1 = 8-bit).
  - bits 6:4 hold the ROM wait count and bit 7 is the ROM width.
  - bits 10:8 hold the extended-memory wait count and bit 11 is its width.
  - bit 12 is the ROM merge flag and bit 13 is the RAM merge flag.
- R3: The block accepts a request on a clock edge where it is idle and `cpu_req` is high. Strobes start in the next cycle. Each strobe phase lasts 1 + W cycles, where W is the region's wait count. `cpu_ready` is high only in the final cycle of the final phase.
- R4: A read holds `ext_oe_n` low. A write holds `ext_we_n` low with `ext_doe` high. The two strobes are never low together.
- R5: In an 8-bit region an access runs two phases. Phase one has `ext_a0`=0 and phase two has `ext_a0`=1. On writes, `ext_dout[7:0]` carries the low byte and then the high byte, and `ext_dout[15:8]` is zero.
- R6: An 8-bit read returns {second byte, first byte} on `cpu_rdata` in the ready cycle. `cpu_rdata` is zero in every other cycle.
- R7: After every strobe phase there is at least one cycle with all chip selects, both strobes and `ext_doe` inactive.
- R8: When the RAM merge flag is set, the RAM select is low in every cycle where the extended-memory select is low.
- R9: When the ROM merge flag is set, the ROM select is low in every cycle where the extended-memory select is low.
- R10: Bits 15:14 of the control register read back as zero, and writing them changes no behaviour.
- R11: Reset clears the register to zero, which means 16-bit width, no wait states and no merging. It also deasserts all selects, strobes and ready.
- R12: A 16-bit region runs one phase with `ext_a0`=0 and passes all 16 data bits in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr | input | 1 | Control register write enable |
| cfg_wdata | input | 16 | Control register write data |
| cfg_rdata | output | 16 | Control register readback |
| cpu_req | input | 1 | Access request, held until ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address; the top two bits pick the region |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data, valid in the ready cycle |
| cpu_ready | output | 1 | Access completes this cycle |
| ext_addr | output | ADDR_W | External word address |
| ext_a0 | output | 1 | Byte select during 8-bit phases |
| ext_xmem_cs_n | output | 1 | Extended-memory select, active low |
| ext_ram_cs_n | output | 1 | RAM select, active low |
| ext_rom_cs_n | output | 1 | ROM select, active low |
| ext_oe_n | output | 1 | Read strobe, active low |
| ext_we_n | output | 1 | Write strobe, active low |
| ext_doe | output | 1 | Drive enable for `ext_dout` |
| ext_dout | output | DATA_W | External write data |
| ext_din | input | DATA_W | External read data |

## Verification
The bench builds the block with ADDR_W=12, DATA_W=16 and MERGE_EN=1. A 12-bit address makes all four region codes easy to reach. Keeping the merge variant in the build puts both merge paths, alone and together, under check. Its wait counts run from zero to the maximum of seven, on both 8-bit and 16-bit regions. This checks every phase length, the byte ordering and the idle cycle between byte phases against a per-cycle model.

// File: rtl/xwc_pkg.sv
`timescale 1ns/1ps
package xwc_pkg;
   localparam int WAIT_W = 3;
   localparam int NRGN   = 3;

   typedef enum logic [1:0] {
      RGN_XMEM = 2'd0,
      RGN_RAM  = 2'd1,
      RGN_ROM  = 2'd2
   } rgn_e;

   // per-region settings: width flag above the wait count
   typedef struct packed {
      logic              narrow;
      logic [WAIT_W-1:0] waits;
   } rgn_cfg_t;

   // packed so that bit positions match the register layout
   typedef struct packed {
      logic     ram_merge;
      logic     rom_merge;
      rgn_cfg_t xmem;
      rgn_cfg_t rom;
      rgn_cfg_t ram;
   } ctl_t;

   function automatic rgn_cfg_t pick_cfg(input ctl_t c, input rgn_e r);
      case (r)
         RGN_RAM: return c.ram;
         RGN_ROM: return c.rom;
         default: return c.xmem;
      endcase
   endfunction
endpackage

// File: rtl/xwc_cfg_reg.sv
`timescale 1ns/1ps
module xwc_cfg_reg
   import xwc_pkg::*;
#(
   parameter int REG_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [REG_W-1:0] wdata,
   output ctl_t             ctl_q,
   output logic [REG_W-1:0] rdata
);
   localparam int CTL_W = $bits(ctl_t);

   generate
      if (REG_W <= CTL_W) begin : g_bad_w
         $error("xwc_cfg_reg: REG_W must exceed the control field width");
      end
   endgenerate

   logic unused_rsvd;
   assign unused_rsvd = ^wdata[REG_W-1:CTL_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctl_q <= '0;
      else if (wr)
         ctl_q <= ctl_t'(wdata[CTL_W-1:0]);
   end

   assign rdata = {{(REG_W-CTL_W){1'b0}}, ctl_q};
endmodule

// File: rtl/xwc_seq.sv
`timescale 1ns/1ps
module xwc_seq
   import xwc_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     req,
   input  rgn_e     rgn_in,
   input  rgn_cfg_t rc_in,
   output logic     accept,
   output logic     active,
   output logic     phase,
   output logic     narrow,
   output logic     ready,
   output logic     cap_lo,
   output rgn_e     rgn_q
);
   typedef enum logic [1:0] {S_IDLE, S_ACT, S_GAP} st_e;

   st_e               st;
   logic [WAIT_W-1:0] cnt;
   logic              more;
   rgn_cfg_t          rc_q;
   logic              last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= S_IDLE;
         cnt   <= '0;
         more  <= 1'b0;
         phase <= 1'b0;
         rc_q  <= '0;
         rgn_q <= RGN_XMEM;
      end else begin
         case (st)
            S_IDLE: if (req) begin
               st    <= S_ACT;
               cnt   <= rc_in.waits;
               rc_q  <= rc_in;
               rgn_q <= rgn_in;
               phase <= 1'b0;
            end
            S_ACT: if (cnt != '0) begin
               cnt <= cnt - 1'b1;
            end else begin
               st   <= S_GAP;
               more <= rc_q.narrow && !phase;
            end
            S_GAP: if (more) begin
               st    <= S_ACT;
               phase <= 1'b1;
               cnt   <= rc_q.waits;
               more  <= 1'b0;
            end else begin
               st <= S_IDLE;
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   assign accept = (st == S_IDLE) && req;
   assign active = (st == S_ACT);
   assign narrow = rc_q.narrow;
   assign last   = active && (cnt == '0);
   assign ready  = last && (!rc_q.narrow || phase);
   assign cap_lo = last && rc_q.narrow && !phase;

   // R7: a strobe phase is always followed by a quiet cycle
   a_r7_quiet_after_phase: assert property (@(posedge clk) disable iff (!rst_n)
      last |=> !active);
   // R3: the first strobe cycle follows an accepted request
   a_r3_start_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> active);
endmodule

// File: rtl/xwc_datapath.sv
`timescale 1ns/1ps
module xwc_datapath #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              cap_lo,
   input  logic              ready,
   input  logic              active,
   input  logic              phase,
   input  logic              narrow,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   input  logic [DATA_W-1:0] ext_din,
   output logic              we_q,
   output logic [ADDR_W-1:0] ext_addr,
   output logic [DATA_W-1:0] ext_dout,
   output logic              ext_doe,
   output logic [DATA_W-1:0] cpu_rdata
);
   localparam int BYTE_W = DATA_W / 2;

   generate
      if (DATA_W % 2 != 0) begin : g_bad_dw
         $error("xwc_datapath: DATA_W must be even");
      end
   endgenerate

   logic [DATA_W-1:0] wd_q;
   logic [BYTE_W-1:0] lo_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_q     <= 1'b0;
         ext_addr <= '0;
         wd_q     <= '0;
         lo_q     <= '0;
      end else begin
         if (accept) begin
            we_q     <= cpu_we;
            ext_addr <= cpu_addr;
            wd_q     <= cpu_wdata;
         end
         if (cap_lo && !we_q)
            lo_q <= ext_din[BYTE_W-1:0];
      end
   end

   always_comb begin
      if (!narrow)
         ext_dout = wd_q;
      else if (phase)
         ext_dout = {{BYTE_W{1'b0}}, wd_q[DATA_W-1:BYTE_W]};
      else
         ext_dout = {{BYTE_W{1'b0}}, wd_q[BYTE_W-1:0]};
   end

   always_comb begin
      cpu_rdata = '0;
      if (ready && !we_q)
         cpu_rdata = narrow ? {ext_din[BYTE_W-1:0], lo_q} : ext_din;
   end

   assign ext_doe = active && we_q;

   // R6: read data leaves the block only in a read's ready cycle
   a_r6_rdata_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rdata != '0) |-> (ready && !we_q));
endmodule

// File: rtl/xmem_wait_ctrl.sv
`timescale 1ns/1ps
module xmem_wait_ctrl
   import xwc_pkg::*;
#(
   parameter int         ADDR_W   = 16,
   parameter int         DATA_W   = 16,
   parameter int         CFG_W    = 16,
   parameter bit         MERGE_EN = 1'b1,
   parameter logic [1:0] RAM_CODE = 2'b10,
   parameter logic [1:0] ROM_CODE = 2'b11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [CFG_W-1:0]  cfg_wdata,
   output logic [CFG_W-1:0]  cfg_rdata,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              cpu_ready,
   output logic [ADDR_W-1:0] ext_addr,
   output logic              ext_a0,
   output logic              ext_xmem_cs_n,
   output logic              ext_ram_cs_n,
   output logic              ext_rom_cs_n,
   output logic              ext_oe_n,
   output logic              ext_we_n,
   output logic              ext_doe,
   output logic [DATA_W-1:0] ext_dout,
   input  logic [DATA_W-1:0] ext_din
);
   generate
      if (ADDR_W < 4) begin : g_bad_aw
         $error("xmem_wait_ctrl: ADDR_W too small for region decode");
      end
      if (RAM_CODE == ROM_CODE) begin : g_bad_codes
         $error("xmem_wait_ctrl: RAM and ROM region codes must differ");
      end
   endgenerate

   ctl_t     ctl;
   rgn_e     rgn_dec, rgn_q;
   rgn_cfg_t rc_dec;
   logic     accept, active, phase, narrow, ready, cap_lo, we_q;
   logic [1:0] code;

   assign code    = cpu_addr[ADDR_W-1 -: 2];
   assign rgn_dec = (code == ROM_CODE) ? RGN_ROM :
                    (code == RAM_CODE) ? RGN_RAM : RGN_XMEM;
   assign rc_dec  = pick_cfg(ctl, rgn_dec);

   xwc_cfg_reg #(.REG_W(CFG_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .wdata(cfg_wdata),
      .ctl_q(ctl), .rdata(cfg_rdata)
   );

   xwc_seq u_seq (
      .clk(clk), .rst_n(rst_n), .req(cpu_req), .rgn_in(rgn_dec), .rc_in(rc_dec),
      .accept(accept), .active(active), .phase(phase), .narrow(narrow),
      .ready(ready), .cap_lo(cap_lo), .rgn_q(rgn_q)
   );

   xwc_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
      .clk(clk), .rst_n(rst_n), .accept(accept), .cap_lo(cap_lo), .ready(ready),
      .active(active), .phase(phase), .narrow(narrow), .cpu_we(cpu_we),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .ext_din(ext_din),
      .we_q(we_q), .ext_addr(ext_addr), .ext_dout(ext_dout), .ext_doe(ext_doe),
      .cpu_rdata(cpu_rdata)
   );

   // one select per region, bit index equals the region encoding
   logic [NRGN-1:0] hit, sel;
   for (genvar i = 0; i < NRGN; i++) begin : g_hit
      assign hit[i] = active && (rgn_q == rgn_e'(i));
   end

   if (MERGE_EN) begin : g_merge
      assign sel = hit | {ctl.rom_merge & hit[RGN_XMEM],
                          ctl.ram_merge & hit[RGN_XMEM], 1'b0};
      // R8: RAM select follows the extended-memory select
      a_r8_ram_follows: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg_rdata[13] && !ext_xmem_cs_n) |-> !ext_ram_cs_n);
      // R9: ROM select follows the extended-memory select
      a_r9_rom_follows: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg_rdata[12] && !ext_xmem_cs_n) |-> !ext_rom_cs_n);
   end else begin : g_plain
      assign sel = hit;
   end

   assign ext_xmem_cs_n = !sel[RGN_XMEM];
   assign ext_ram_cs_n  = !sel[RGN_RAM];
   assign ext_rom_cs_n  = !sel[RGN_ROM];
   assign ext_oe_n      = !(active && !we_q);
   assign ext_we_n      = !(active && we_q);
   assign ext_a0        = active && phase;
   assign cpu_ready     = ready;

   // R4: read and write strobes never overlap
   a_r4_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(!ext_oe_n && !ext_we_n));
   // R1: without merging, at most one chip select is low
   a_r1_single_sel: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rdata[13:12] == 2'b00) |->
      ($countones({~ext_xmem_cs_n, ~ext_ram_cs_n, ~ext_rom_cs_n}) <= 1));
   // R5: the second byte phase opens only after a quiet cycle
   a_r5_a0_after_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ext_a0) |-> $past(ext_oe_n && ext_we_n));
   // R3: ready only while a strobe is asserted
   a_r3_ready_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |-> !(ext_oe_n && ext_we_n));
endmodule

// File: tb/xmem_wait_ctrl_test.sv
`timescale 1ns/1ps
module xmem_wait_ctrl_test;
   localparam int AW = 12;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_wr = 1'b0;
   logic [15:0]   cfg_wdata = '0;
   logic [15:0]   cfg_rdata;
   logic          cpu_req = 1'b0, cpu_we = 1'b0;
   logic [AW-1:0] cpu_addr = '0;
   logic [DW-1:0] cpu_wdata = '0, cpu_rdata;
   logic          cpu_ready;
   logic [AW-1:0] ext_addr;
   logic          ext_a0, ext_xmem_cs_n, ext_ram_cs_n, ext_rom_cs_n;
   logic          ext_oe_n, ext_we_n, ext_doe;
   logic [DW-1:0] ext_dout, ext_din;

   int checks = 0;
   int errors = 0;
   logic [15:0] cfg_m = '0;

   always #5 clk = ~clk;

   xmem_wait_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CFG_W(16), .MERGE_EN(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .cpu_req(cpu_req), .cpu_we(cpu_we),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
      .cpu_ready(cpu_ready), .ext_addr(ext_addr), .ext_a0(ext_a0),
      .ext_xmem_cs_n(ext_xmem_cs_n), .ext_ram_cs_n(ext_ram_cs_n),
      .ext_rom_cs_n(ext_rom_cs_n), .ext_oe_n(ext_oe_n), .ext_we_n(ext_we_n),
      .ext_doe(ext_doe), .ext_dout(ext_dout), .ext_din(ext_din)
   );

   function automatic logic [15:0] pat(input logic [AW-1:0] a);
      return {a[3:0], a[11:4]} ^ 16'hC35A;
   endfunction

   // external memory: byte lane 0 carries the upper byte when a0 is high
   always_comb ext_din = ext_a0 ? {8'h5A, pat(ext_addr)[15:8]} : pat(ext_addr);

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic check_quiet(input string tag);
      chk({tag, " R7 selects/strobes quiet"},
          {ext_xmem_cs_n, ext_ram_cs_n, ext_rom_cs_n, ext_oe_n, ext_we_n, ext_doe, ext_a0, cpu_ready},
          8'b1111_1000);
      chk({tag, " R6 rdata zero when idle"}, cpu_rdata, 16'h0);
   endtask

   task automatic wcfg(input logic [15:0] v);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_wdata = v;
      @(negedge clk);
      cfg_wr = 1'b0;
      cfg_m = v & 16'h3FFF;
      chk("R10 R2 register readback", cfg_rdata, cfg_m);
   endtask

   task automatic run(input logic we, input logic [AW-1:0] addr, input logic [15:0] wd,
                      input string tag);
      int r, w, nph;
      logic nar, rdy;
      logic [2:0] exp_cs;
      logic [15:0] exp_do;
      r   = (addr[AW-1 -: 2] == 2'b11) ? 2 : (addr[AW-1 -: 2] == 2'b10) ? 1 : 0;
      w   = (r == 0) ? cfg_m[10:8] : (r == 2) ? cfg_m[6:4] : cfg_m[2:0];
      nar = (r == 0) ? cfg_m[11]   : (r == 2) ? cfg_m[7]   : cfg_m[3];
      nph = nar ? 2 : 1;
      exp_cs[2] = !(r == 0);
      exp_cs[1] = !((r == 1) || (r == 0 && cfg_m[13]));
      exp_cs[0] = !((r == 2) || (r == 0 && cfg_m[12]));
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
      check_quiet({tag, " R3 before accept"});
      for (int ph = 0; ph < nph; ph++) begin
         for (int c = 0; c <= w; c++) begin
            @(negedge clk);
            rdy = (ph == nph - 1) && (c == w);
            chk({tag, " R1/R8/R9 selects"}, {ext_xmem_cs_n, ext_ram_cs_n, ext_rom_cs_n}, exp_cs);
            chk({tag, " R4 strobes"}, {ext_oe_n, ext_we_n, ext_doe}, {we, !we, we});
            chk({tag, " R5/R12 a0"}, ext_a0, nar ? ph[0] : 1'b0);
            chk({tag, " R3 ready"}, cpu_ready, rdy);
            chk({tag, " R3 address"}, ext_addr, addr);
            if (we) begin
               exp_do = !nar ? wd : (ph == 1) ? {8'h00, wd[15:8]} : {8'h00, wd[7:0]};
               chk({tag, " R5/R12 write data"}, ext_dout, exp_do);
            end
            chk({tag, " R6/R12 read data"}, cpu_rdata, (rdy && !we) ? pat(addr) : 16'h0);
         end
         if (ph == nph - 1) cpu_req = 1'b0;
         else begin
            @(negedge clk);
            check_quiet({tag, " R7 between bytes"});
         end
      end
      @(negedge clk);
      check_quiet({tag, " R7 after access"});
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R11 register reset", cfg_rdata, 16'h0);
      check_quiet("R11 reset outputs");
      rst_n = 1'b1;
      run(1'b0, 12'h123, 16'h0, "R11 default region");
      wcfg(16'hFFFF);
      wcfg(16'hC000);
      run(1'b1, 12'h2AB, 16'hBEEF, "R10 reserved ignored");
      wcfg(16'h029B);
      run(1'b1, 12'h0F0, 16'h1357, "R4 xmem write");
      run(1'b0, 12'h5A5, 16'h0,    "R1 xmem code01");
      run(1'b1, 12'h812, 16'hA1B2, "R5 ram narrow write");
      run(1'b0, 12'h9FE, 16'h0,    "R6 ram narrow read");
      run(1'b0, 12'hC34, 16'h0,    "R6 rom narrow read");
      run(1'b1, 12'hF00, 16'h00FF, "R1 rom write");
      wcfg(16'h377F);
      run(1'b0, 12'h3C3, 16'h0,    "R8 R9 both merged");
      run(1'b1, 12'hB00, 16'h7E81, "R3 ram wait7 narrow");
      run(1'b0, 12'hE0E, 16'h0,    "R3 rom wait7 wide");
      wcfg(16'h2000);
      run(1'b1, 12'h0AA, 16'h4242, "R8 ram merge only");
      wcfg(16'h1800);
      run(1'b0, 12'h155, 16'h0,    "R9 rom merge narrow xmem");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL R3 watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule